// File: doc/BRIEF.md
# Double-Rate Read Burst Pipeline

This block is the read data path of a double-data-rate memory model. On each rising edge of the command clock it takes one command: a read, a burst stop, a bank close (precharge) or no operation. A read starts a burst of `BURST_LEN` words. The words come from a computed array model and leave the block two per clock, so a burst takes `BURST_LEN/2` clocks. The first pair appears `CAS_LAT` clocks after the read.

A strobe-enable output marks every clock that carries a word pair. A bus drive enable rises one clock earlier as a preamble and stays high while data flows. A later read cuts off the running burst and its data follows on without a gap. A burst stop ends the burst. So does a close of the bank being read. After either, the bus goes idle `CAS_LAT` clocks later. An idle bus is modelled as zero words with both enables low.

Top module: `ddr_rd_path`

## Requirements
- R1: While reset is high, and on the first clock after it, both enables are low and both words are zero. Reset also discards any burst in flight.
- R2: A read sampled at rising edge E puts its first word pair on the outputs right after edge E+`CAS_LAT`. Strobe enable then stays high for exactly `BURST_LEN/2` clocks, unless a later command cuts the burst.
- R3: Each output word encodes its location. The bank goes in bits 31:30, zeros in bits 29:10 and the column in bits 9:0. Within one clock, the first word is the earlier of the pair.
- R4: Word k of a burst (k from 0) reads the column whose upper bits match the start column. Its low log2(`BURST_LEN`) bits are (start + k) mod `BURST_LEN`. This is sequential order that wraps inside the aligned block.
- R5: Drive enable rises one clock before the first word pair of a run of data. It is high on every clock on which strobe enable is high.
- R6: A read issued one or more clocks after an earlier read ends the earlier burst at that point. The new burst's pairs follow the earlier burst's last pair on the very next clock.
- R7: A burst stop (cmd=2) sampled at edge E ends a burst started by a read with `cmd_flag`=0. The last pair is the one from the clock before E, and the bus is idle from edge E+`CAS_LAT`. The bank input is ignored.
- R8: A burst stop has no effect on a burst whose read was issued with `cmd_flag`=1 (auto-precharge).
- R9: A burst stop that arrives after the running burst has fetched its last pair changes nothing on the outputs.
- R10: A close (cmd=3) ends the burst in the same way as R7 when its bank matches the bank being read, or when `cmd_flag`=1 (all banks). A close to a different bank with `cmd_flag`=0 has no effect.
- R11: Whenever strobe enable is low, both output words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; everything samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command code: 0 none, 1 read, 2 burst stop, 3 close bank |
| cmd_bank | input | 2 | Bank for a read or close |
| cmd_col | input | 10 | Start column for a read |
| cmd_flag | input | 1 | Auto-precharge on a read; all banks on a close |
| dq_word0 | output | 32 | First word of the pair in this clock |
| dq_word1 | output | 32 | Second word of the pair in this clock |
| dq_strobe_en | output | 1 | High on clocks that carry a word pair |
| dq_drive_en | output | 1 | Bus drive enable, including a one-clock preamble |

## Verification
Some properties hold on every clock, and assertions check them. Strobe enable implies drive enable. A rising drive enable is followed by data. Every read is followed by data after the CAS latency. The two words in a pair are consecutive in wrap order. Idle words are zero. Other behaviour depends on which command came when, so only the bench scenarios can show it. That covers the exact cycle on which a stop or close cuts a burst, the immunity of auto-precharge reads, the seamless hand-over between reads, the close that targets another bank, and a late stop that does nothing.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

    parameter int DATA_W = 32;
    parameter int BANK_W = 2;
    parameter int COL_W  = 10;

    typedef enum logic [1:0] {
        RCMD_NOP   = 2'd0,
        RCMD_READ  = 2'd1,
        RCMD_STOP  = 2'd2,
        RCMD_CLOSE = 2'd3
    } rcmd_e;

    // One clock's worth of read work: two column addresses in one bank
    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col_a;
        logic [COL_W-1:0]  col_b;
    } beat_t;

    // Computed array model: each location returns its own address
    function automatic logic [DATA_W-1:0] cell_value(
        input logic [BANK_W-1:0] bank,
        input logic [COL_W-1:0]  col
    );
        return {bank, {(DATA_W-BANK_W-COL_W){1'b0}}, col};
    endfunction

endpackage

// File: rtl/rd_burst_seq.sv
module rd_burst_seq
    import ddr_rd_pkg::*;
#(
    parameter int BURST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  rcmd_e             cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic              flag,
    output beat_t             beat
);
    localparam int LB    = $clog2(BURST_LEN);
    localparam int BEATS = BURST_LEN / 2;
    localparam int CW    = $clog2(BEATS + 1);

    logic              act;
    logic              apre;
    logic [BANK_W-1:0] bk;
    logic [COL_W-1:LB] col_hi;
    logic [LB-1:0]     ofs;
    logic [CW-1:0]     left;
    logic              cut;

    // Stop honours auto-precharge; close honours bank or all-banks
    assign cut = ((cmd == RCMD_STOP) && !apre) ||
                 ((cmd == RCMD_CLOSE) && (flag || (bank == bk)));

    always_comb begin
        beat.vld   = act;
        beat.bank  = bk;
        beat.col_a = {col_hi, ofs};
        beat.col_b = {col_hi, LB'(ofs + 1'b1)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= 1'b0;
            apre   <= 1'b0;
            bk     <= '0;
            col_hi <= '0;
            ofs    <= '0;
            left   <= '0;
        end else if (cmd == RCMD_READ) begin
            act    <= 1'b1;
            apre   <= flag;
            bk     <= bank;
            col_hi <= col[COL_W-1:LB];
            ofs    <= col[LB-1:0];
            left   <= CW'(BEATS);
        end else if (act && cut) begin
            act <= 1'b0;
        end else if (act) begin
            ofs  <= LB'(ofs + 2'd2);
            left <= left - CW'(1);
            if (left == CW'(1)) act <= 1'b0;
        end
    end

endmodule

// File: rtl/rd_beat_pipe.sv
module rd_beat_pipe
    import ddr_rd_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t in_beat,
    output beat_t out_beat,
    output logic  next_vld
);
    beat_t stg [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stg[i] <= '0;
                else if (i == 0) stg[i] <= in_beat;
                else             stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
        end
        if (DEPTH >= 2) begin : g_pre_stage
            assign next_vld = stg[DEPTH-2].vld;
        end else begin : g_pre_in
            assign next_vld = in_beat.vld;
        end
    endgenerate

    assign out_beat = stg[DEPTH-1];

endmodule

// File: rtl/rd_word_fetch.sv
module rd_word_fetch
    import ddr_rd_pkg::*;
(
    input  beat_t             beat,
    output logic [DATA_W-1:0] word_a,
    output logic [DATA_W-1:0] word_b
);
    always_comb begin
        word_a = '0;
        word_b = '0;
        if (beat.vld) begin
            word_a = cell_value(beat.bank, beat.col_a);
            word_b = cell_value(beat.bank, beat.col_b);
        end
    end
endmodule

// File: rtl/ddr_rd_path.sv
module ddr_rd_path
    import ddr_rd_pkg::*;
#(
    parameter int BURST_LEN = 8,
    parameter int CAS_LAT   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_flag,
    output logic [DATA_W-1:0] dq_word0,
    output logic [DATA_W-1:0] dq_word1,
    output logic              dq_strobe_en,
    output logic              dq_drive_en
);
    beat_t fetch_beat;
    beat_t bus_beat;
    logic  pre_vld;

    rd_burst_seq #(.BURST_LEN(BURST_LEN)) seq_i (
        .clk  (clk),
        .rst  (rst),
        .cmd  (rcmd_e'(cmd)),
        .bank (cmd_bank),
        .col  (cmd_col),
        .flag (cmd_flag),
        .beat (fetch_beat)
    );

    rd_beat_pipe #(.DEPTH(CAS_LAT)) pipe_i (
        .clk      (clk),
        .rst      (rst),
        .in_beat  (fetch_beat),
        .out_beat (bus_beat),
        .next_vld (pre_vld)
    );

    rd_word_fetch fetch_i (
        .beat   (bus_beat),
        .word_a (dq_word0),
        .word_b (dq_word1)
    );

    assign dq_strobe_en = bus_beat.vld;
    assign dq_drive_en  = bus_beat.vld | pre_vld;

endmodule

// File: rtl/ddr_rd_path_chk.sv
module ddr_rd_path_chk
    import ddr_rd_pkg::*;
#(
    parameter int BURST_LEN = 8,
    parameter int CAS_LAT   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cmd,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [COL_W-1:0]  cmd_col,
    input logic              cmd_flag,
    input logic [DATA_W-1:0] dq_word0,
    input logic [DATA_W-1:0] dq_word1,
    input logic              dq_strobe_en,
    input logic              dq_drive_en
);
    localparam int LB = $clog2(BURST_LEN);

    logic [CAS_LAT-1:0] rd_hist;

    always_ff @(posedge clk) begin
        if (rst) rd_hist <= '0;
        else     rd_hist <= (rd_hist << 1) | CAS_LAT'(cmd == 2'd1);
    end

    // R5
    strobe_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
        dq_strobe_en |-> dq_drive_en);

    // R5
    drive_preamble_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_drive_en) |=> dq_strobe_en);

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hist[CAS_LAT-1] |=> dq_strobe_en);

    // R4
    pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        dq_strobe_en |-> (dq_word1[LB-1:0] == LB'(dq_word0[LB-1:0] + 1'b1)) &&
                         (dq_word1[DATA_W-1:LB] == dq_word0[DATA_W-1:LB]));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !dq_strobe_en |-> (dq_word0 == '0) && (dq_word1 == '0));

endmodule

bind ddr_rd_path ddr_rd_path_chk #(.BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT)) chk_i (.*);

// File: tb/ddr_rd_path_tb_top.sv
`timescale 1ns/1ps
module ddr_rd_path_tb_top;
    localparam int BL    = 8;
    localparam int CL    = 3;
    localparam int BEATS = BL / 2;
    localparam int LB    = 3;

    localparam logic [1:0] C_NOP = 2'd0, C_RD = 2'd1, C_STOP = 2'd2, C_CLOSE = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd = C_NOP;
    logic [1:0]  cmd_bank = '0;
    logic [9:0]  cmd_col = '0;
    logic        cmd_flag = 1'b0;
    logic [31:0] dq_word0, dq_word1;
    logic        dq_strobe_en, dq_drive_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ddr_rd_path #(.BURST_LEN(BL), .CAS_LAT(CL)) dut_i (
        .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .cmd_flag(cmd_flag), .dq_word0(dq_word0), .dq_word1(dq_word1),
        .dq_strobe_en(dq_strobe_en), .dq_drive_en(dq_drive_en)
    );

    // stimulus: bank, column, expected first pair (R3 encoding, R4 order)
    typedef struct packed {
        logic [1:0]  bank;
        logic [9:0]  col;
        logic [31:0] w0;
        logic [31:0] w1;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd1, 10'h010, 32'h4000_0010, 32'h4000_0011},
        '{2'd2, 10'h0A5, 32'h8000_00A5, 32'h8000_00A6},
        '{2'd3, 10'h3FF, 32'hC000_03FF, 32'hC000_03F8},
        '{2'd0, 10'h123, 32'h0000_0123, 32'h0000_0124}
    };

    function automatic logic [31:0] exp_word(input logic [1:0] b, input logic [9:0] c, input int k);
        logic [LB-1:0] low;
        low = LB'(int'(c[LB-1:0]) + k);
        return {b, 20'b0, c[9:LB], low};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic [1:0] b, input logic [9:0] col, input logic f);
        cmd = c; cmd_bank = b; cmd_col = col; cmd_flag = f;
    endtask

    // Read A at N0, then command B at negedge offset g; checks every clock until idle
    task automatic run2(input logic [1:0] ba, input logic [9:0] ca, input logic apa,
                        input logic [1:0] cb, input logic [1:0] bb, input logic [9:0] colb,
                        input logic fb, input int g, input string tag,
                        input logic [31:0] f0, input logic [31:0] f1);
        int a_end, b_start, b_end, last;
        a_end = BEATS; b_start = -1000; b_end = -1000;
        if (cb == C_RD) begin
            a_end = (g < BEATS) ? g : BEATS; b_start = g; b_end = g + BEATS;
        end
        if (cb == C_STOP && !apa && g < BEATS) a_end = g;
        if (cb == C_CLOSE && (fb || bb == ba) && g < BEATS) a_end = g;
        last = (a_end > b_end) ? a_end : b_end;
        drive(C_RD, ba, ca, apa);
        @(negedge clk);
        for (int c = 1; c <= CL + last + 1; c++) begin
            int j;
            logic ev, evn;
            logic [31:0] e0, e1;
            if (c == g) drive(cb, bb, colb, fb);
            else        drive(C_NOP, 2'd0, 10'd0, 1'b0);
            j = c - CL - 1;
            ev  = (j >= 0 && j < a_end) || (j >= b_start && j < b_end);
            evn = (j + 1 >= 0 && j + 1 < a_end) || (j + 1 >= b_start && j + 1 < b_end);
            e0 = '0; e1 = '0;
            if (j == 0 && a_end > 0) begin
                e0 = f0; e1 = f1;
            end else if (j >= 0 && j < a_end) begin
                e0 = exp_word(ba, ca, 2*j); e1 = exp_word(ba, ca, 2*j+1);
            end else if (j >= b_start && j < b_end) begin
                e0 = exp_word(bb, colb, 2*(j-b_start)); e1 = exp_word(bb, colb, 2*(j-b_start)+1);
            end
            check({tag, " strobe"}, 32'(dq_strobe_en), 32'(ev));
            check({tag, " drive R5"}, 32'(dq_drive_en), 32'(ev | evn));
            check({tag, " word0 R3"}, dq_word0, e0);
            check({tag, " word1 R4"}, dq_word1, e1);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset
        check("R1 reset strobe", 32'(dq_strobe_en), 32'd0);
        check("R1 reset drive", 32'(dq_drive_en), 32'd0);
        check("R1 reset word0", dq_word0, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset drive", 32'(dq_drive_en), 32'd0);

        // R2 R3 R4: vector table walked by one loop, plain bursts
        for (int i = 0; i < 4; i++)
            run2(VECS[i].bank, VECS[i].col, 1'b0, C_NOP, 2'd0, 10'd0, 1'b0, 1,
                 "R2 table", VECS[i].w0, VECS[i].w1);

        // R6: new read one and three clocks later
        run2(2'd1, 10'h004, 1'b0, C_RD, 2'd2, 10'h031, 1'b0, 1, "R6 gap1",
             exp_word(2'd1, 10'h004, 0), exp_word(2'd1, 10'h004, 1));
        run2(2'd0, 10'h007, 1'b0, C_RD, 2'd3, 10'h100, 1'b0, 3, "R6 gap3",
             exp_word(2'd0, 10'h007, 0), exp_word(2'd0, 10'h007, 1));

        // R7: stop cuts, bank input differs from read bank
        run2(2'd2, 10'h040, 1'b0, C_STOP, 2'd1, 10'd0, 1'b0, 2, "R7 stop",
             exp_word(2'd2, 10'h040, 0), exp_word(2'd2, 10'h040, 1));
        // R8: auto-precharge read ignores stop
        run2(2'd2, 10'h040, 1'b1, C_STOP, 2'd2, 10'd0, 1'b0, 2, "R8 apre",
             exp_word(2'd2, 10'h040, 0), exp_word(2'd2, 10'h040, 1));
        // R9: late stop after last fetch does nothing
        run2(2'd1, 10'h022, 1'b0, C_STOP, 2'd1, 10'd0, 1'b0, BEATS, "R9 late",
             exp_word(2'd1, 10'h022, 0), exp_word(2'd1, 10'h022, 1));
        run2(2'd1, 10'h022, 1'b0, C_STOP, 2'd1, 10'd0, 1'b0, BEATS + 1, "R9 later",
             exp_word(2'd1, 10'h022, 0), exp_word(2'd1, 10'h022, 1));
        // R10: close same bank, other bank, all banks
        run2(2'd3, 10'h055, 1'b0, C_CLOSE, 2'd3, 10'd0, 1'b0, 3, "R10 same",
             exp_word(2'd3, 10'h055, 0), exp_word(2'd3, 10'h055, 1));
        run2(2'd3, 10'h055, 1'b0, C_CLOSE, 2'd0, 10'd0, 1'b0, 2, "R10 other",
             exp_word(2'd3, 10'h055, 0), exp_word(2'd3, 10'h055, 1));
        run2(2'd3, 10'h055, 1'b0, C_CLOSE, 2'd0, 10'd0, 1'b1, 1, "R10 all",
             exp_word(2'd3, 10'h055, 0), exp_word(2'd3, 10'h055, 1));

        // R1: reset in the middle of a burst discards it
        drive(C_RD, 2'd1, 10'h011, 1'b0);
        @(negedge clk);
        drive(C_NOP, 2'd0, 10'd0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < CL + BEATS + 1; c++) begin
            check("R1 flush strobe", 32'(dq_strobe_en), 32'd0);
            check("R11 flush word1", dq_word1, 32'd0);
            @(negedge clk);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule